// File: doc/BRIEF.md
# Serial Display-Configuration Receiver

This block accepts a 45-bit configuration word from a host over three wires: a data line, a shift clock and a strobe. All three are synchronized into the system clock. Each rising edge of the shift clock moves one data bit into a holding shift register. A rising edge of the strobe copies the held word into the active configuration register. Before that copy, each field is checked against its legal codes. A prohibited field keeps its previous value and raises the error flag. The delay code is capped at a limit that depends on the clock-range code.

A select input chooses between the loaded configuration and a fixed set of defaults. A one-cycle clear request puts the active register back to the defaults, clears the error flag and empties the holding register.

The receiver is controlled by a three-state machine. `ST_IDLE` means no bits have arrived since the last commit. `ST_SHIFT` means at least one bit has been shifted. `ST_COMMIT` is a single cycle in which the active register is updated. The transitions are:
- `ST_IDLE` to `ST_SHIFT` on a shift-clock rise.
- `ST_IDLE` or `ST_SHIFT` to `ST_COMMIT` on a strobe rise.
- `ST_COMMIT` to `ST_SHIFT` if a shift-clock rise arrives in the same cycle, otherwise to `ST_IDLE`.
- Any state to `ST_IDLE` on a clear request.

Top module: `cfg_serial_rx`

## Requirements
- R1: Word bit k (k = 0 to 44) is the k-th bit sampled on a shift-clock rising edge, so bit 0 is sent first. Each field is sent most significant bit first, in this order: expansion code (bits 0-3), vertical start (4-14, 11 bits), delay code (15-21, 7 bits), edge select (22), horizontal start (23-31, 9 bits), line length (32-42, 11 bits), range code (43-44).
- R2: Shifting bits changes no output. The active register changes only on a strobe rising edge, and that edge commits whatever the holding register contains at that moment.
- R3: While `use_default_i` is 1, the outputs are expansion 0000, ratio 20, vertical start 35, delay 0, edge 0, horizontal start 296, line length 1344, range 01, and error 0. The loaded values come back when `use_default_i` returns to 0.
- R4: `exp_ratio_o` gives the vertical magnification in twentieths: code 0000 gives 20, 0001 gives 25, 0010 gives 32, 0101 gives 50, 0110 gives 64.
- R5: Expansion codes 0011, 0111 and 1xxx are prohibited. Loading one raises the error flag and keeps the previous expansion code.
- R6: A vertical start below 4 or a horizontal start below 64 is prohibited. The error flag rises and that field keeps its previous value. Exactly 4 and exactly 64 are accepted.
- R7: Range code 00 is prohibited. The error flag rises and the previous range code is kept.
- R8: The stored delay is the smaller of the loaded delay code and the cap for the range code that ends up stored: 59h for range 01, 6Bh for 10, 7Fh for 11. Clamping does not raise the error flag.
- R9: A clear request returns the active register to the R3 defaults, clears the error flag and discards the held bits. The clear takes effect on the next cycle.
- R10: After reset, the outputs equal the R3 defaults and the error flag is 0.
- R11: The error flag reflects only the most recent commit. A commit with no prohibited field clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdat_i | input | 1 | Serial data (asynchronous) |
| sstb_i | input | 1 | Serial strobe (asynchronous) |
| use_default_i | input | 1 | 1 = force the default configuration |
| clr_i | input | 1 | Clear request, one system-clock pulse |
| exp_code_o | output | 4 | Expansion mode code |
| exp_ratio_o | output | 7 | Vertical magnification in twentieths |
| vstart_o | output | 11 | Vertical start, in lines |
| dly_o | output | 7 | Clock-delay code after capping |
| edge_o | output | 1 | Sampling-edge select |
| hstart_o | output | 9 | Horizontal start, in clocks |
| linelen_o | output | 11 | Line length, in clocks |
| range_o | output | 2 | Clock-range code |
| err_o | output | 1 | Last commit contained a prohibited field |

## Verification
Two functions can act in the same commit: the range-code check and the delay cap. A word with a prohibited range code and a delay above the cap forces the cap to come from the previously stored range code. The bench sends exactly that word. It expects the delay capped at the old range's limit, the range code unchanged, and the error flag raised. The bench also sends a word with several prohibited fields next to legal ones. It judges each field on its own: prohibited fields hold their value while legal fields in the same word are updated.

// File: rtl/cfg_rx_pkg.sv
`timescale 1ns/1ps
package cfg_rx_pkg;
    localparam int EXP_W   = 4;
    localparam int VST_W   = 11;
    localparam int DLY_W   = 7;
    localparam int HST_W   = 9;
    localparam int LEN_W   = 11;
    localparam int RNG_W   = 2;
    localparam int RATIO_W = 7;
    localparam int FRAME_W = EXP_W + VST_W + DLY_W + 1 + HST_W + LEN_W + RNG_W;

    // Field order equals transmission order; first-sent bit lands at the MSB.
    typedef struct packed {
        logic [EXP_W-1:0] exp_code;
        logic [VST_W-1:0] vst;
        logic [DLY_W-1:0] dly;
        logic             edge_sel;
        logic [HST_W-1:0] hst;
        logic [LEN_W-1:0] len;
        logic [RNG_W-1:0] rng;
    } cfg_t;

    localparam logic [VST_W-1:0] VST_MIN = VST_W'(4);
    localparam logic [HST_W-1:0] HST_MIN = HST_W'(64);

    localparam cfg_t CFG_DEFAULT = '{
        exp_code: '0,
        vst:      VST_W'(35),
        dly:      '0,
        edge_sel: 1'b0,
        hst:      HST_W'(296),
        len:      LEN_W'(1344),
        rng:      RNG_W'(1)
    };

    function automatic logic exp_legal(input logic [EXP_W-1:0] c);
        case (c)
            4'b0000, 4'b0001, 4'b0010, 4'b0101, 4'b0110: return 1'b1;
            default:                                     return 1'b0;
        endcase
    endfunction

    function automatic logic [DLY_W-1:0] dly_cap(input logic [RNG_W-1:0] r);
        case (r)
            2'b10:   return DLY_W'(8'h6B);
            2'b11:   return DLY_W'(8'h7F);
            default: return DLY_W'(8'h59);
        endcase
    endfunction

    function automatic logic [RATIO_W-1:0] exp_ratio(input logic [EXP_W-1:0] c);
        case (c)
            4'b0001: return RATIO_W'(25);
            4'b0010: return RATIO_W'(32);
            4'b0101: return RATIO_W'(50);
            4'b0110: return RATIO_W'(64);
            default: return RATIO_W'(20);
        endcase
    endfunction
endpackage

// File: rtl/cfg_rx_sync.sv
`timescale 1ns/1ps
module cfg_rx_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES:0] pipe_q;
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= {pipe_q[STAGES-1:0], async_i[b]};
        end
        assign lvl_o[b]  = pipe_q[STAGES-1];
        assign rise_o[b] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    end
endmodule

// File: rtl/cfg_rx_fsm.sv
`timescale 1ns/1ps
module cfg_rx_fsm #(
    parameter int FRAME_W = 45
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               sclk_rise_i,
    input  logic               sdat_i,
    input  logic               stb_rise_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               commit_o
);
    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_COMMIT} st_e;

    st_e state_q, state_d;
    logic [FRAME_W-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (stb_rise_i) state_d = ST_COMMIT;
                           else if (sclk_rise_i) state_d = ST_SHIFT;
                ST_SHIFT:  if (stb_rise_i) state_d = ST_COMMIT;
                ST_COMMIT: state_d = sclk_rise_i ? ST_SHIFT : ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        commit_o = (state_q == ST_COMMIT);
        frame_o  = frame_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  frame_q <= '0;
        else if (sclk_rise_i) frame_q <= {frame_q[FRAME_W-2:0], sdat_i};
    end
endmodule

// File: rtl/cfg_rx_check.sv
`timescale 1ns/1ps
module cfg_rx_check
    import cfg_rx_pkg::*;
(
    input  cfg_t raw_i,
    input  cfg_t cur_i,
    output cfg_t nxt_o,
    output logic bad_o
);
    logic exp_ok, vst_ok, hst_ok, rng_ok;
    logic [DLY_W-1:0] cap;

    always_comb begin
        exp_ok = exp_legal(raw_i.exp_code);
        vst_ok = raw_i.vst >= VST_MIN;
        hst_ok = raw_i.hst >= HST_MIN;
        rng_ok = raw_i.rng != '0;

        nxt_o.exp_code = exp_ok ? raw_i.exp_code : cur_i.exp_code;
        nxt_o.vst      = vst_ok ? raw_i.vst      : cur_i.vst;
        nxt_o.hst      = hst_ok ? raw_i.hst      : cur_i.hst;
        nxt_o.rng      = rng_ok ? raw_i.rng      : cur_i.rng;
        nxt_o.edge_sel = raw_i.edge_sel;
        nxt_o.len      = raw_i.len;

        cap       = dly_cap(nxt_o.rng);
        nxt_o.dly = (raw_i.dly > cap) ? cap : raw_i.dly;

        bad_o = !(exp_ok && vst_ok && hst_ok && rng_ok);
    end
endmodule

// File: rtl/cfg_serial_rx.sv
`timescale 1ns/1ps
module cfg_serial_rx
    import cfg_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               sdat_i,
    input  logic               sstb_i,
    input  logic               use_default_i,
    input  logic               clr_i,
    output logic [EXP_W-1:0]   exp_code_o,
    output logic [RATIO_W-1:0] exp_ratio_o,
    output logic [VST_W-1:0]   vstart_o,
    output logic [DLY_W-1:0]   dly_o,
    output logic               edge_o,
    output logic [HST_W-1:0]   hstart_o,
    output logic [LEN_W-1:0]   linelen_o,
    output logic [RNG_W-1:0]   range_o,
    output logic               err_o
);
    localparam int LINES = 3;

    logic [LINES-1:0] lvl, rise;
    logic [FRAME_W-1:0] frame;
    logic commit;
    cfg_t raw, act_q, act_d, sel;
    logic err_q, bad;

    cfg_rx_sync #(.N(LINES), .STAGES(2)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({sstb_i, sdat_i, sclk_i}),
        .lvl_o  (lvl),
        .rise_o (rise)
    );

    cfg_rx_fsm #(.FRAME_W(FRAME_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .sclk_rise_i(rise[0]),
        .sdat_i     (lvl[1]),
        .stb_rise_i (rise[2]),
        .frame_o    (frame),
        .commit_o   (commit)
    );

    assign raw = cfg_t'(frame);

    cfg_rx_check i_check (
        .raw_i(raw),
        .cur_i(act_q),
        .nxt_o(act_d),
        .bad_o(bad)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            act_q <= CFG_DEFAULT;
            err_q <= 1'b0;
        end else if (commit) begin
            act_q <= act_d;
            err_q <= bad;
        end
    end

    always_comb begin
        sel         = use_default_i ? CFG_DEFAULT : act_q;
        exp_code_o  = sel.exp_code;
        exp_ratio_o = exp_ratio(sel.exp_code);
        vstart_o    = sel.vst;
        dly_o       = sel.dly;
        edge_o      = sel.edge_sel;
        hstart_o    = sel.hst;
        linelen_o   = sel.len;
        range_o     = sel.rng;
        err_o       = err_q & ~use_default_i;
    end
endmodule

// File: rtl/cfg_serial_rx_chk.sv
`timescale 1ns/1ps
module cfg_serial_rx_chk
    import cfg_rx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             use_default_i,
    input logic             commit,
    input cfg_t             act_q,
    input logic             err_q,
    input logic [EXP_W-1:0] exp_code_o,
    input logic [VST_W-1:0] vstart_o,
    input logic [DLY_W-1:0] dly_o,
    input logic             edge_o,
    input logic [HST_W-1:0] hstart_o,
    input logic [LEN_W-1:0] linelen_o,
    input logic [RNG_W-1:0] range_o,
    input logic             err_o
);
    assert_hold_between_commits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !clr_i) |=> ($stable(act_q) && $stable(err_q)));

    assert_commit_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_defaults_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        use_default_i |-> (exp_code_o == '0 && vstart_o == VST_W'(35) && dly_o == '0 &&
                           !edge_o && hstart_o == HST_W'(296) && linelen_o == LEN_W'(1344) &&
                           range_o == RNG_W'(1) && !err_o));

    assert_exp_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exp_legal(exp_code_o));

    assert_start_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vstart_o >= VST_MIN) && (hstart_o >= HST_MIN));

    assert_range_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        range_o != '0);

    assert_delay_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dly_o <= dly_cap(range_o));

    assert_clear_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!err_o && vstart_o == VST_W'(35) && hstart_o == HST_W'(296) &&
                   linelen_o == LEN_W'(1344)));
endmodule

bind cfg_serial_rx cfg_serial_rx_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_i),
    .use_default_i(use_default_i),
    .commit       (commit),
    .act_q        (act_q),
    .err_q        (err_q),
    .exp_code_o   (exp_code_o),
    .vstart_o     (vstart_o),
    .dly_o        (dly_o),
    .edge_o       (edge_o),
    .hstart_o     (hstart_o),
    .linelen_o    (linelen_o),
    .range_o      (range_o),
    .err_o        (err_o)
);

// File: tb/test_cfg_serial_rx.sv
`timescale 1ns/1ps
module test_cfg_serial_rx;
    import cfg_rx_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_i = 1'b0, sdat_i = 1'b0, sstb_i = 1'b0;
    logic use_default_i = 1'b0, clr_i = 1'b0;
    logic [EXP_W-1:0]   exp_code_o;
    logic [RATIO_W-1:0] exp_ratio_o;
    logic [VST_W-1:0]   vstart_o;
    logic [DLY_W-1:0]   dly_o;
    logic               edge_o;
    logic [HST_W-1:0]   hstart_o;
    logic [LEN_W-1:0]   linelen_o;
    logic [RNG_W-1:0]   range_o;
    logic               err_o;

    always #2.5 clk = ~clk;

    cfg_serial_rx i_cfg_serial_rx (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdat_i(sdat_i), .sstb_i(sstb_i),
        .use_default_i(use_default_i), .clr_i(clr_i),
        .exp_code_o(exp_code_o), .exp_ratio_o(exp_ratio_o), .vstart_o(vstart_o),
        .dly_o(dly_o), .edge_o(edge_o), .hstart_o(hstart_o), .linelen_o(linelen_o),
        .range_o(range_o), .err_o(err_o)
    );

    typedef struct {
        cfg_t  c;
        logic  e;
        string tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    cfg_t m_act;
    logic m_err;

    function automatic logic [6:0] ref_ratio(input logic [3:0] c);
        case (c)
            4'b0001: return 7'd25;
            4'b0010: return 7'd32;
            4'b0101: return 7'd50;
            4'b0110: return 7'd64;
            default: return 7'd20;
        endcase
    endfunction

    function automatic logic [6:0] ref_cap(input logic [1:0] r);
        return (r == 2'b11) ? 7'h7F : (r == 2'b10) ? 7'h6B : 7'h59;
    endfunction

    function automatic cfg_t mk(input logic [3:0] e, input int v, input logic [6:0] d,
                                input logic ed, input int h, input int l, input logic [1:0] r);
        cfg_t c;
        c.exp_code = e; c.vst = VST_W'(v); c.dly = d; c.edge_sel = ed;
        c.hst = HST_W'(h); c.len = LEN_W'(l); c.rng = r;
        return c;
    endfunction

    // Reference model of a commit, from R5..R8 and R11
    task automatic model_commit(input cfg_t w);
        logic bad;
        bad = 1'b0;
        if (w.exp_code inside {4'b0000, 4'b0001, 4'b0010, 4'b0101, 4'b0110}) m_act.exp_code = w.exp_code;
        else bad = 1'b1;
        if (w.vst >= 4)  m_act.vst = w.vst; else bad = 1'b1;
        if (w.hst >= 64) m_act.hst = w.hst; else bad = 1'b1;
        if (w.rng != 0)  m_act.rng = w.rng; else bad = 1'b1;
        m_act.edge_sel = w.edge_sel;
        m_act.len = w.len;
        m_act.dly = (w.dly > ref_cap(m_act.rng)) ? ref_cap(m_act.rng) : w.dly;
        m_err = bad;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic expect_now(input string tag);
        item_t it;
        it.c   = use_default_i ? mk(4'b0, 35, 7'h0, 1'b0, 296, 1344, 2'b01) : m_act;
        it.e   = use_default_i ? 1'b0 : m_err;
        it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    task automatic shift_word(input cfg_t w);
        logic [FRAME_W-1:0] f;
        f = w;
        for (int k = 0; k < FRAME_W; k++) begin
            sdat_i = f[FRAME_W-1-k];
            repeat (5) @(negedge clk);
            sclk_i = 1'b1;
            repeat (10) @(negedge clk);
            sclk_i = 1'b0;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic strobe();
        sstb_i = 1'b1;
        repeat (10) @(negedge clk);
        sstb_i = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic load(input cfg_t w, input string tag);
        shift_word(w);
        strobe();
        model_commit(w);
        expect_now(tag);
    endtask

    // Monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            item_t it;
            wait (q.size() > 0);
            repeat (8) @(negedge clk);
            it = q[0];
            check({it.tag, " fields"},
                  64'({exp_code_o, vstart_o, dly_o, edge_o, hstart_o, linelen_o, range_o}),
                  64'(it.c));
            check({it.tag, " error flag"}, 64'(err_o), 64'(it.e));
            check({it.tag, " ratio R4"}, 64'(exp_ratio_o), 64'(ref_ratio(it.c.exp_code)));
            void'(q.pop_front());
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cfg_t wb;
        m_act = mk(4'b0, 35, 7'h0, 1'b0, 296, 1344, 2'b01);
        m_err = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_now("R10 reset defaults");

        // R1 R4: legal word, every field applied
        load(mk(4'b0010, 100, 7'h30, 1'b1, 200, 1000, 2'b10), "R1 legal word A");

        // R2: shifting alone changes nothing, a bare strobe then commits it
        wb = mk(4'b0110, 2047, 7'h7F, 1'b0, 511, 2047, 2'b11);
        shift_word(wb);
        expect_now("R2 shifted without strobe");
        strobe();
        model_commit(wb);
        expect_now("R2 bare strobe commits held word");

        // R5: prohibited expansion codes
        load(mk(4'b0011, 300, 7'h10, 1'b1, 100, 800, 2'b11), "R5 code 0011 kept");
        load(mk(4'b1010, 301, 7'h11, 1'b0, 101, 801, 2'b11), "R5 code 1xxx kept");

        // R6 with R8: low starts rejected, other fields in the word still update
        load(mk(4'b0101, 3, 7'h7F, 1'b1, 63, 900, 2'b01), "R6 starts below floor");

        // R7 with R8: range 00 rejected, cap taken from kept range 01
        load(mk(4'b0001, 500, 7'h70, 1'b0, 300, 1200, 2'b00), "R7 range 00 cap from old R8");

        // R6 boundaries, R8 cap for range 10, R11 clean word clears error
        load(mk(4'b0001, 4, 7'h6C, 1'b1, 64, 0, 2'b10), "R6 R8 R11 boundary word");
        load(mk(4'b0110, 40, 7'h6B, 1'b0, 70, 1344, 2'b10), "R8 cap exact not clamped");

        // R3: defaults forced, then loaded values return
        load(mk(4'b0101, 3, 7'h05, 1'b1, 80, 1500, 2'b11), "R5 R6 error before select");
        use_default_i = 1'b1;
        expect_now("R3 defaults forced");
        use_default_i = 1'b0;
        expect_now("R3 loaded values restored");

        // R9: clear returns to defaults, discards held bits
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        m_act = mk(4'b0, 35, 7'h0, 1'b0, 296, 1344, 2'b01);
        m_err = 1'b0;
        expect_now("R9 clear");
        strobe();
        model_commit('0);
        expect_now("R9 held bits discarded");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule